// File: doc/BRIEF.md
# Paged MDIO Register Bridge

This block lets a host perform 32-bit register reads and writes on a device whose register space is reached through Clause 22 MDIO with paged addressing. The host presents a register byte address, a direction and, for writes, a 32-bit word. The block splits the address into a page number, a PHY sub-select and a register index. It then runs three MDIO frames: a page-select write, two data frames for the high and low half-words, and a settle wait between the page write and the first data frame.

The serial engine generates MDC from the system clock through a parameterised divider. It drives MDIO while the block owns the line and releases it for the turnaround and data bits of a read. A read returns the two half-words joined into one 32-bit word, and sets a flag when the word is all ones, which is what a missing device gives on a pulled-up line. The done output is a single-cycle pulse.

Top module: `paged_mdio_bridge`

## Requirements
- R1: From byte address A (18 bits), the register index is (A>>1)&0x1E, the sub-select is (A>>6)&0x7 and the page is (A>>9)&0x1FF. Bit 0 of A has no effect.
- R2: Each access starts with a write frame to PHY address 0x18, register 0, carrying the page in the low 9 data bits with the upper bits zero.
- R3: Between the end of the page frame and the first MDC rise of the next frame, MDC stays low for at least SETTLE_CYC system clock cycles.
- R4: Both data frames use PHY address 0x10 OR the sub-select.
- R5: A read reads register index first (low half), then index+1 (high half). It returns rdata_o = {high, low}.
- R6: A write sends wdata_i[31:16] to index+1 first, then wdata_i[15:0] to index.
- R7: When done_o pulses for a read, absent_o is 1 exactly when rdata_o is 0xFFFFFFFF. At the end of a write, absent_o is 0.
- R8: Each frame is 64 bits, MSB first: 32 ones, start 01, opcode (01 write, 10 read), 5-bit PHY, 5-bit register, turnaround, 16 data bits. A write drives turnaround 10. A read releases MDIO (mdio_oe_o=0) from the turnaround through the last data bit. MDIO changes while MDC is low. Read bits are sampled at the MDC rise.
- R9: MDC high and low phases each last MDC_HALF system clock cycles. MDC is low while the block is idle.
- R10: busy_o is 1 from the cycle after a request is accepted until done_o. done_o lasts one cycle with busy_o low. Requests while busy_o is 1 start no frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, taken when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Register byte address |
| wdata_i | input | 32 | Write data |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read result {high, low} |
| absent_o | output | 1 | Read returned all ones |
| mdc_o | output | 1 | MDIO clock |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input data |

## Verification
The assertions assume the following about the inputs:
- The host holds address, data and direction valid in the cycle req_i is high.
- mdio_i reads as high whenever neither side drives the line.

The bench keeps to this. It pulses req_i for one cycle, with its fields set on the same falling edge. Its MDIO target model drives only in the data window of a read. Otherwise it lets the line float high, and that is also how it models an absent device. One extra request is injected mid-access to confirm that no frame comes from it.

// File: rtl/paged_mdio_pkg.sv
package paged_mdio_pkg;
  localparam int IDX_W   = 5;
  localparam int SUB_W   = 3;
  localparam int PAGE_W  = 9;
  localparam int ADDR_W  = 1 + (IDX_W - 1) + 1 + SUB_W + PAGE_W;
  localparam int HALF_W  = 16;
  localparam int WORD_W  = 2 * HALF_W;
  localparam int PHY_W   = 5;
  localparam logic [PHY_W-1:0] PAGE_PHY  = 5'h18;
  localparam logic [IDX_W-1:0] PAGE_REG  = 5'h00;
  localparam logic [PHY_W-1:0] DATA_PHY  = 5'h10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PAGE, ST_SETTLE, ST_XA, ST_XB
  } seq_st_e;
endpackage

// File: rtl/mdio_addr_split.sv
module mdio_addr_split
  import paged_mdio_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [SUB_W-1:0]  sub_o,
  output logic [PAGE_W-1:0] page_o
);
  localparam int SUB_LSB  = IDX_W + 1;
  localparam int PAGE_LSB = SUB_LSB + SUB_W;

  // index is always even: low bit of the word pair
  assign idx_o  = {addr_i[IDX_W:2], 1'b0};
  assign sub_o  = addr_i[PAGE_LSB-1:SUB_LSB];
  assign page_o = addr_i[ADDR_W-1:PAGE_LSB];
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import paged_mdio_pkg::*;
#(
  parameter int MDC_HALF = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [PHY_W-1:0]  phy_i,
  input  logic [IDX_W-1:0]  reg_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic              done_o,
  output logic [HALF_W-1:0] rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  localparam int FRAME_LEN = 64;
  localparam int BW        = $clog2(FRAME_LEN);
  localparam int DW        = $clog2(MDC_HALF + 1);
  localparam int TA_POS    = FRAME_LEN - HALF_W - 2;
  localparam int DATA_POS  = FRAME_LEN - HALF_W;

  logic                 active_q, half_q, rd_q;
  logic [BW-1:0]        bit_q;
  logic [DW-1:0]        div_q;
  logic [FRAME_LEN-1:0] frame_q;
  logic [HALF_W-1:0]    rsh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      half_q   <= 1'b0;
      rd_q     <= 1'b0;
      bit_q    <= '0;
      div_q    <= '0;
      frame_q  <= '1;
      rsh_q    <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          half_q   <= 1'b0;
          bit_q    <= '0;
          div_q    <= '0;
          rd_q     <= rd_i;
          frame_q  <= {32'hFFFF_FFFF, 2'b01, rd_i ? 2'b10 : 2'b01, phy_i, reg_i,
                       rd_i ? 2'b11 : 2'b10, rd_i ? {HALF_W{1'b0}} : wdata_i};
        end
      end else if (div_q == DW'(MDC_HALF - 1)) begin
        div_q <= '0;
        if (!half_q) begin
          half_q <= 1'b1;
          if (rd_q && bit_q >= BW'(DATA_POS)) rsh_q <= {rsh_q[HALF_W-2:0], mdio_i};
        end else begin
          half_q <= 1'b0;
          if (bit_q == BW'(FRAME_LEN - 1)) begin
            active_q <= 1'b0;
            done_o   <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign mdc_o     = active_q & half_q;
  assign mdio_o    = active_q ? frame_q[BW'(FRAME_LEN - 1) - bit_q] : 1'b1;
  assign mdio_oe_o = active_q & ~(rd_q & (bit_q >= BW'(TA_POS)));
  assign rdata_o   = rsh_q;

  // R8
  frame_end_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mdc_o && !mdio_oe_o);
  // R9
  mdc_edge_on_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && $past(active_q) && (mdc_o != $past(mdc_o)) |-> div_q == '0);
endmodule

// File: rtl/paged_mdio_bridge.sv
module paged_mdio_bridge
  import paged_mdio_pkg::*;
#(
  parameter int MDC_HALF   = 5,
  parameter int SETTLE_CYC = 250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              absent_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  seq_st_e           st_q;
  logic              we_q, eng_start_q, eng_done, eng_rd;
  logic [IDX_W-1:0]  idx_q, idx_d, eng_reg;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [WORD_W-1:0] wdata_q;
  logic [HALF_W-1:0] lo_q, eng_rdata, eng_wdata;
  logic [PHY_W-1:0]  eng_phy;
  logic [SW-1:0]     settle_q;

  mdio_addr_split i_split (
    .addr_i (addr_i),
    .idx_o  (idx_d),
    .sub_o  (sub_d),
    .page_o (page_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      we_q        <= 1'b0;
      idx_q       <= '0;
      sub_q       <= '0;
      page_q      <= '0;
      wdata_q     <= '0;
      lo_q        <= '0;
      settle_q    <= '0;
      eng_start_q <= 1'b0;
      done_o      <= 1'b0;
      rdata_o     <= '0;
      absent_o    <= 1'b0;
    end else begin
      done_o      <= 1'b0;
      eng_start_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          we_q        <= we_i;
          idx_q       <= idx_d;
          sub_q       <= sub_d;
          page_q      <= page_d;
          wdata_q     <= wdata_i;
          st_q        <= ST_PAGE;
          eng_start_q <= 1'b1;
        end
        ST_PAGE: if (eng_done) begin
          st_q     <= ST_SETTLE;
          settle_q <= '0;
        end
        ST_SETTLE: if (settle_q == SW'(SETTLE_CYC - 1)) begin
          st_q        <= ST_XA;
          eng_start_q <= 1'b1;
        end else begin
          settle_q <= settle_q + 1'b1;
        end
        ST_XA: if (eng_done) begin
          lo_q        <= eng_rdata;
          st_q        <= ST_XB;
          eng_start_q <= 1'b1;
        end
        ST_XB: if (eng_done) begin
          st_q   <= ST_IDLE;
          done_o <= 1'b1;
          if (we_q) begin
            absent_o <= 1'b0;
          end else begin
            rdata_o  <= {eng_rdata, lo_q};
            absent_o <= &{eng_rdata, lo_q};
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // reads: low then high; writes: high then low
  always_comb begin
    eng_phy   = {DATA_PHY[PHY_W-1:SUB_W], sub_q};
    eng_rd    = ~we_q;
    eng_reg   = idx_q;
    eng_wdata = wdata_q[HALF_W-1:0];
    unique case (st_q)
      ST_XA: begin
        eng_reg   = we_q ? (idx_q | 1'b1) : idx_q;
        eng_wdata = wdata_q[WORD_W-1:HALF_W];
      end
      ST_XB: eng_reg = we_q ? idx_q : (idx_q | 1'b1);
      default: begin
        eng_phy   = PAGE_PHY;
        eng_reg   = PAGE_REG;
        eng_rd    = 1'b0;
        eng_wdata = {{(HALF_W - PAGE_W){1'b0}}, page_q};
      end
    endcase
  end

  mdio_frame_engine #(.MDC_HALF(MDC_HALF)) i_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (eng_start_q),
    .rd_i      (eng_rd),
    .phy_i     (eng_phy),
    .reg_i     (eng_reg),
    .wdata_i   (eng_wdata),
    .done_o    (eng_done),
    .rdata_o   (eng_rdata),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .mdio_i    (mdio_i)
  );

  assign busy_o = (st_q != ST_IDLE);

  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  busy_req_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && req_i |=> $stable(page_q) && $stable(idx_q) && $stable(sub_q) && $stable(we_q));
  // R9
  idle_mdc_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdc_o && !mdio_oe_o);
  // R3
  settle_before_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_q && st_q == ST_XA |-> $past(st_q) == ST_SETTLE);
endmodule

// File: tb/test_paged_mdio_bridge.sv
module test_paged_mdio_bridge;
  localparam int HALF   = 3;
  localparam int SETTLE = 40;
  localparam int PER    = 4;

  typedef struct {
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  regi;
    logic [15:0] data;
    bit          chk_data;
    string       tag;
  } fr_t;

  logic        clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [17:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        busy, done, absent, mdc, mdio_out, mdio_oe, mdio_in;
  logic [31:0] rdata;
  logic        slave_drv = 1'b1;
  bit          slave_absent = 1'b0;
  int          total = 0, bad = 0;
  bit          finished = 1'b0;
  fr_t         exp_q[$];
  logic [15:0] mem [0:1023];

  always #(PER/2) clk = ~clk;
  assign mdio_in = mdio_oe ? mdio_out : slave_drv;

  paged_mdio_bridge #(.MDC_HALF(HALF), .SETTLE_CYC(SETTLE)) i_paged_mdio_bridge (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .absent_o(absent), .mdc_o(mdc), .mdio_o(mdio_out), .mdio_oe_o(mdio_oe),
    .mdio_i(mdio_in)
  );

  task automatic chk(bit ok, string req_tag, logic [63:0] act, logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req_tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // MDIO target model and scoreboard monitor
  int     k = 0, frame_no = 0;
  logic   fb [0:63];
  logic [15:0] rd_word = '1;
  logic [1:0]  m_op;
  logic [4:0]  m_phy, m_reg;
  bit     fmt_ok = 1'b1;
  time    last_rise = 0, last_fall = 0;

  always @(posedge mdc) begin
    fb[k] = mdio_in;
    if (k == 0) begin
      fmt_ok = 1'b1;
      if (frame_no % 3 == 1)  // R3: gap after page frame
        chk(($time - last_fall) >= SETTLE * PER, "R3 settle gap", $time - last_fall, SETTLE * PER);
    end
    if (k < 32 && fb[k] !== 1'b1) fmt_ok = 1'b0;
    if (k == 32 && fb[k] !== 1'b0) fmt_ok = 1'b0;
    if (k == 33 && fb[k] !== 1'b1) fmt_ok = 1'b0;
    if (k == 45) begin
      m_op  = {fb[34], fb[35]};
      m_phy = {fb[36], fb[37], fb[38], fb[39], fb[40]};
      m_reg = {fb[41], fb[42], fb[43], fb[44], fb[45]};
      rd_word = slave_absent ? 16'hFFFF : mem[{m_phy, m_reg}];
    end
    if (k < 45 && mdio_oe !== 1'b1) fmt_ok = 1'b0;
    if (k >= 46 && m_op == 2'b10 && mdio_oe !== 1'b0) fmt_ok = 1'b0;
    if (k >= 46 && m_op == 2'b01 && mdio_oe !== 1'b1) fmt_ok = 1'b0;
    if (k == 46 && m_op == 2'b01 && fb[k] !== 1'b1) fmt_ok = 1'b0;
    if (k == 47 && m_op == 2'b01 && fb[k] !== 1'b0) fmt_ok = 1'b0;
    last_rise = $time;
    if (k == 63) begin
      logic [15:0] d;
      d = '0;
      for (int i = 48; i < 64; i++) d = {d[14:0], fb[i]};
      chk(fmt_ok, "R8 frame format", {63'b0, fmt_ok}, 64'd1);
      if (m_op == 2'b01 && !slave_absent) mem[{m_phy, m_reg}] = d;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected frame", {m_op, m_phy, m_reg}, 0);
      end else begin
        fr_t e;
        e = exp_q.pop_front();
        chk(m_op == e.op && m_phy == e.phy && m_reg == e.regi && (!e.chk_data || d == e.data),
            e.tag, {m_op, m_phy, m_reg, d}, {e.op, e.phy, e.regi, e.data});
      end
      frame_no++;
      k = 0;
    end else begin
      k++;
    end
  end

  always @(negedge mdc) begin
    last_fall = $time;
    if (k == 11)  // R9: high phase length
      chk(($time - last_rise) == HALF * PER, "R9 mdc high", $time - last_rise, HALF * PER);
    if (k >= 48 && m_op == 2'b10 && !slave_absent) slave_drv = rd_word[63 - k];
    else slave_drv = 1'b1;
  end

  always @(posedge mdc) begin
    if (k == 12)  // R9: low phase length (k already advanced)
      chk(($time - last_fall) == HALF * PER, "R9 mdc low", $time - last_fall, HALF * PER);
  end

  task automatic push_fr(logic [1:0] op, logic [4:0] phy, logic [4:0] r, logic [15:0] d, bit cd, string t);
    fr_t f;
    f.op = op; f.phy = phy; f.regi = r; f.data = d; f.chk_data = cd; f.tag = t;
    exp_q.push_back(f);
  endtask

  task automatic access(bit w, logic [17:0] a, logic [31:0] wd, logic [31:0] exp_rd,
                        bit exp_abs, bit inject);
    logic [4:0] idx, phy;
    logic [8:0] page;
    idx  = (a >> 1) & 5'h1E;       // R1
    phy  = 5'h10 | ((a >> 6) & 3'h7);
    page = (a >> 9) & 9'h1FF;
    push_fr(2'b01, 5'h18, 5'h00, {7'b0, page}, 1'b1, "R2 page frame");
    if (w) begin
      push_fr(2'b01, phy, idx | 5'h1, wd[31:16], 1'b1, "R6 write high first");
      push_fr(2'b01, phy, idx, wd[15:0], 1'b1, "R6 write low second");
    end else begin
      push_fr(2'b10, phy, idx, 16'h0, 1'b0, "R5 read low first");
      push_fr(2'b10, phy, idx | 5'h1, 16'h0, 1'b0, "R4 R5 read high second");
    end
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = wd;
    @(negedge clk);
    req = 1'b0; addr = '0; wdata = '0;
    chk(busy === 1'b1, "R10 busy after accept", busy, 1);
    if (inject) begin
      repeat (50) @(negedge clk);
      req = 1'b1; we = 1'b1; addr = 18'h00004; wdata = 32'h5555_AAAA;
      @(negedge clk);
      req = 1'b0;
    end
    while (done !== 1'b1) @(negedge clk);
    chk(busy === 1'b0, "R10 busy low at done", busy, 0);
    if (!w) chk(rdata === exp_rd, "R5 read data", rdata, exp_rd);
    chk(absent === exp_abs, "R7 absent flag", absent, exp_abs);
    @(negedge clk);
    chk(done === 1'b0, "R10 done one cycle", done, 0);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0 && busy === 1'b0 && mdc === 1'b0, "R10 no extra frames",
        exp_q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && mdc === 1'b0 && mdio_oe === 1'b0,
        "R9 reset idle", {busy, done, mdc, mdio_oe}, 0);
    // R1: page 0x1FF, sub 5, idx 0x1E
    access(1'b1, 18'h3FF7C, 32'hDEAD_BEEF, 0, 1'b0, 1'b0);
    access(1'b0, 18'h3FF7C, 0, 32'hDEAD_BEEF, 1'b0, 1'b0);
    // R1: page 0x0A3, sub 2, idx 6; bit 0 set on read has no effect
    access(1'b1, 18'h1468C, 32'h1234_FFFF, 0, 1'b0, 1'b0);
    access(1'b0, 18'h1468D, 0, 32'h1234_FFFF, 1'b0, 1'b0);
    // R7: absent device reads all ones
    slave_absent = 1'b1;
    access(1'b0, 18'h1468C, 0, 32'hFFFF_FFFF, 1'b1, 1'b0);
    slave_absent = 1'b0;
    // R7: a write clears the flag
    access(1'b1, 18'h00040, 32'h0000_0001, 0, 1'b0, 1'b0);
    // R10: request during busy is ignored
    access(1'b0, 18'h3FF7C, 0, 32'hDEAD_BEEF, 1'b0, 1'b1);
    access(1'b0, 18'h00040, 0, 32'h0000_0001, 1'b0, 1'b0);
    finish_run();
  end

  initial begin
    #(PER * 100000);
    total++; bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    finish_run();
  end
endmodule